// File: doc/BRIEF.md
# Frequency-Change Watchdog with Revert

This block guards software-driven clock frequency changes. Software first loads a timeout of 1 to 15 seconds. It then writes a new frequency selection or alters an output divider ratio. Either change arms a countdown. If software does not write the timeout field back to zero before the countdown ends, the block raises an alarm flag and forces a safe frequency selection onto its output. It also starts a timed low pulse on an open-drain system reset line, so the platform reboots at a frequency known to work.

The block keeps two entries of software frequency history, the current selection and the one before it. A revert-mode bit chooses the safe value on timeout: either the latched hardware strap value or the software selection that preceded the failing one. The reset line shares a pin with a clock-stop input. A pin-mode bit decides whether the block may drive that pin at all. The one-second base and the pulse width come from a parameterised system-clock rate, so a bench can shrink both. The PLL that consumes the selection lies outside the block.

Top module: `freq_wd_revert`

## Requirements
- R1: During and right after synchronous reset, `fs_out` equals `strap_fs`, `wd_alarm` is 0 and `srst_pull_low` is 0. Both history entries hold the strap value.
- R2: A cycle with `sw_fs_wr` high loads `sw_fs` onto `fs_out` at the next clock edge. The previous current selection becomes the history entry. This happens whatever the timeout field holds.
- R3: `wd_timeout` is a 4-bit field: 0 means the watchdog is off, and 1 to 15 give a timeout in whole seconds. A cycle with `sw_fs_wr` or `div_chg` high while the field is nonzero starts the countdown. Expiry happens at the clock edge exactly `wd_timeout` × `CLK_HZ` edges after the starting edge. A change while the field is 0 starts nothing.
- R4: A further change strobe during a running countdown restarts the full period from that strobe.
- R5: While `wd_timeout` is 0, the countdown is stopped and `wd_alarm` reads 0 from the next edge on.
- R6: At expiry `wd_alarm` becomes 1 and stays 1 until `wd_timeout` is written to 0.
- R7: At expiry with `revert_sel` = 0, `fs_out` takes the current `strap_fs` value.
- R8: At expiry with `revert_sel` = 1, `fs_out` takes the software selection in force before the latest write. If only one write happened since reset, that is the strap value from reset. The restored value becomes the current selection.
- R9: At expiry with `pin_mode` = 0, `srst_pull_low` is 1 for exactly `CLK_HZ/1000 × PULSE_MS` cycles, starting from the expiry edge.
- R10: `pin_mode` = 1 (the pin serves as a clock-stop input) keeps `srst_pull_low` at 0. An expiry in that mode starts no pulse.
- R11: An expiry while a reset pulse is running does not restart or extend that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wd_timeout | input | 4 | Timeout field: 0 off, 1..15 seconds |
| revert_sel | input | 1 | Safe value on expiry: 0 strap, 1 prior software selection |
| pin_mode | input | 1 | 1 = shared pin is a clock-stop input, 0 = reset output |
| strap_fs | input | 5 | Latched hardware frequency strap |
| sw_fs | input | 5 | Software frequency selection value |
| sw_fs_wr | input | 1 | Strobe: software writes `sw_fs` |
| div_chg | input | 1 | Strobe: an output divider ratio changed |
| fs_out | output | 5 | Frequency selection in force |
| wd_alarm | output | 1 | Watchdog expired flag |
| srst_pull_low | output | 1 | Open-drain enable: 1 pulls the reset pin low |

## Verification
The costly faults are a countdown that is off by one second or one cycle, a history that shifts at the wrong moment, and a pulse counter that reloads. A wrong count moves the rise of `wd_alarm` and the revert of `fs_out` away from the exact expiry edge. A stale history entry shows as the wrong value on `fs_out` in the cycle after expiry. A reloading pulse shows as `srst_pull_low` staying high past its fixed width. The reference model is compared with all three outputs on every cycle, so each of these shows at the first cycle where the ports diverge. Directed checks add the exact edges of expiry and pulse end.

// File: rtl/wdr_pkg.sv
package wdr_pkg;

    localparam int FS_W  = 5;
    localparam int TMO_W = 4;

    typedef logic [FS_W-1:0]  fs_t;
    typedef logic [TMO_W-1:0] tmo_t;

    typedef enum logic {
        WD_IDLE  = 1'b0,
        WD_COUNT = 1'b1
    } wd_state_t;

    // control for the countdown, decoded once at the top
    typedef struct packed {
        logic cancel;
        logic start;
    } wd_cmd_t;

    // two-deep software selection history
    typedef struct packed {
        fs_t cur;
        fs_t prev;
    } fs_hist_t;

    function automatic logic tmo_is_off(tmo_t t);
        return t == '0;
    endfunction

    function automatic fs_t safe_pick(logic use_sw, fs_t prior_sw, fs_t strap);
        return use_sw ? prior_sw : strap;
    endfunction

endpackage

// File: rtl/wdr_sec_timer.sv
module wdr_sec_timer
    import wdr_pkg::*;
#(
    parameter int unsigned SEC_CYC = 1000
) (
    input  logic    clk,
    input  logic    rst,
    input  wd_cmd_t cmd,
    input  tmo_t    tmo,
    output logic    expire,
    output logic    running
);

    localparam int unsigned CW = (SEC_CYC > 1) ? $clog2(SEC_CYC) : 1;
    localparam logic [CW-1:0] CYC_LAST = CW'(SEC_CYC - 1);
    localparam logic [CW-1:0] CYC_ONE  = CW'(1);
    localparam tmo_t          SEC_ONE  = tmo_t'(1);

    wd_state_t     st;
    logic [CW-1:0] cyc;
    tmo_t          secs;
    logic          sec_end;

    assign sec_end = (cyc == CYC_LAST);
    assign running = (st == WD_COUNT);
    // a cancel or a fresh start in the same cycle wins over expiry
    assign expire  = running && sec_end && (secs == SEC_ONE) && !cmd.cancel && !cmd.start;

    always_ff @(posedge clk) begin
        if (rst || cmd.cancel) begin
            st   <= WD_IDLE;
            cyc  <= '0;
            secs <= '0;
        end else if (cmd.start) begin
            st   <= WD_COUNT;
            cyc  <= '0;
            secs <= tmo;
        end else if (running) begin
            if (sec_end) begin
                cyc <= '0;
                if (secs == SEC_ONE) begin
                    st   <= WD_IDLE;
                    secs <= '0;
                end else begin
                    secs <= secs - SEC_ONE;
                end
            end else begin
                cyc <= cyc + CYC_ONE;
            end
        end
    end

    AST_SECS_NONZERO: assert property (@(posedge clk) disable iff (rst)
        running |-> (secs != '0)); // R3

    AST_EXPIRE_STOPS: assert property (@(posedge clk) disable iff (rst)
        expire |=> !running); // R3

    AST_OFF_IDLE: assert property (@(posedge clk) disable iff (rst)
        cmd.cancel |=> !running); // R5

endmodule

// File: rtl/wdr_fs_history.sv
module wdr_fs_history
    import wdr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  fs_t  strap_fs,
    input  fs_t  sw_fs,
    input  logic sw_wr,
    input  logic expire,
    input  logic revert_sel,
    output fs_t  fs_out
);

    fs_hist_t hist;
    fs_t      restore_val;

    assign restore_val = safe_pick(revert_sel, hist.prev, strap_fs);
    assign fs_out      = hist.cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist.cur  <= strap_fs;
            hist.prev <= strap_fs;
        end else if (sw_wr) begin
            hist.prev <= hist.cur;
            hist.cur  <= sw_fs;
        end else if (expire) begin
            hist.cur  <= restore_val;
        end
    end

    AST_FS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        !$stable(fs_out) |-> $past(sw_wr || expire)); // R2

    AST_REVERT_HW: assert property (@(posedge clk) disable iff (rst)
        (expire && !revert_sel && !sw_wr) |=> (fs_out == $past(strap_fs))); // R7

    AST_WRITE_LOAD: assert property (@(posedge clk) disable iff (rst)
        sw_wr |=> (fs_out == $past(sw_fs))); // R2

endmodule

// File: rtl/wdr_pulse_gen.sv
module wdr_pulse_gen #(
    parameter int unsigned PULSE_CYC = 600000
) (
    input  logic clk,
    input  logic rst,
    input  logic expire,
    input  logic pin_mode,
    output logic active
);

    localparam int unsigned PW = $clog2(PULSE_CYC + 1);
    localparam logic [PW-1:0] P_LOAD = PW'(PULSE_CYC);
    localparam logic [PW-1:0] P_ONE  = PW'(1);

    logic [PW-1:0] cnt;

    assign active = (cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (expire && !active && !pin_mode) begin
            cnt <= P_LOAD;
        end else if (active) begin
            cnt <= cnt - P_ONE;
        end
    end

    AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(active) |-> ($past(expire) && !$past(pin_mode))); // R9

    AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (rst)
        ($past(active) && active) |-> ((cnt + P_ONE) == $past(cnt))); // R11

endmodule

// File: rtl/freq_wd_revert.sv
module freq_wd_revert
    import wdr_pkg::*;
#(
    parameter int unsigned CLK_HZ   = 100000000,
    parameter int unsigned PULSE_MS = 6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] wd_timeout,
    input  logic       revert_sel,
    input  logic       pin_mode,
    input  logic [4:0] strap_fs,
    input  logic [4:0] sw_fs,
    input  logic       sw_fs_wr,
    input  logic       div_chg,
    output logic [4:0] fs_out,
    output logic       wd_alarm,
    output logic       srst_pull_low
);

    localparam int unsigned SEC_CYC   = CLK_HZ;
    localparam int unsigned PULSE_CYC = (CLK_HZ / 1000) * PULSE_MS;

    wd_cmd_t cmd;
    logic    expire;
    logic    running;
    logic    pulse_on;
    logic    alarm_q;

    always_comb begin
        cmd.cancel = tmo_is_off(wd_timeout);
        cmd.start  = (sw_fs_wr || div_chg) && !cmd.cancel;
    end

    wdr_sec_timer #(.SEC_CYC(SEC_CYC)) timer_i (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .tmo     (wd_timeout),
        .expire  (expire),
        .running (running)
    );

    wdr_fs_history hist_i (
        .clk        (clk),
        .rst        (rst),
        .strap_fs   (strap_fs),
        .sw_fs      (sw_fs),
        .sw_wr      (sw_fs_wr),
        .expire     (expire),
        .revert_sel (revert_sel),
        .fs_out     (fs_out)
    );

    wdr_pulse_gen #(.PULSE_CYC(PULSE_CYC)) pulse_i (
        .clk      (clk),
        .rst      (rst),
        .expire   (expire),
        .pin_mode (pin_mode),
        .active   (pulse_on)
    );

    always_ff @(posedge clk) begin
        if (rst || cmd.cancel) begin
            alarm_q <= 1'b0;
        end else if (expire) begin
            alarm_q <= 1'b1;
        end
    end

    assign wd_alarm      = alarm_q;
    assign srst_pull_low = pulse_on && !pin_mode;

    AST_ALARM_SOURCE: assert property (@(posedge clk) disable iff (rst)
        $rose(wd_alarm) |-> $past(expire)); // R6

    AST_ALARM_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (wd_timeout == 4'd0) |=> !wd_alarm); // R5

    AST_ALARM_HOLD: assert property (@(posedge clk) disable iff (rst)
        ($past(wd_alarm) && ($past(wd_timeout) != 4'd0)) |-> wd_alarm); // R6

    AST_NO_START_OFF: assert property (@(posedge clk) disable iff (rst)
        ((wd_timeout == 4'd0) && !running) |=> !running); // R3

endmodule

// File: tb/freq_wd_revert_tb.sv
`timescale 1ns/1ps
module freq_wd_revert_tb_top;

    localparam int unsigned TB_HZ  = 1000;
    localparam int unsigned TB_PMS = 1500;
    localparam int SEC = TB_HZ;
    localparam int PUL = (TB_HZ / 1000) * TB_PMS;

    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] wd_timeout;
    logic       revert_sel;
    logic       pin_mode;
    logic [4:0] strap_fs;
    logic [4:0] sw_fs;
    logic       sw_fs_wr;
    logic       div_chg;
    logic [4:0] fs_out;
    logic       wd_alarm;
    logic       srst_pull_low;

    always #2 clk = ~clk;

    freq_wd_revert #(.CLK_HZ(TB_HZ), .PULSE_MS(TB_PMS)) dut_i (
        .clk           (clk),
        .rst           (rst),
        .wd_timeout    (wd_timeout),
        .revert_sel    (revert_sel),
        .pin_mode      (pin_mode),
        .strap_fs      (strap_fs),
        .sw_fs         (sw_fs),
        .sw_fs_wr      (sw_fs_wr),
        .div_chg       (div_chg),
        .fs_out        (fs_out),
        .wd_alarm      (wd_alarm),
        .srst_pull_low (srst_pull_low)
    );

    int    n_chk = 0;
    int    n_bad = 0;
    int    cyc_cnt = 0;
    bit    done = 0;
    string tag = "R1";

    // behavioural reference state
    int m_fs, m_cur, m_prev, m_left, m_alarm, m_pulse;
    bit m_chg, m_exp;

    always @(posedge clk) begin
        if (rst) begin
            m_fs = strap_fs; m_cur = strap_fs; m_prev = strap_fs;
            m_left = 0; m_alarm = 0; m_pulse = 0;
        end else begin
            m_chg = sw_fs_wr || div_chg;
            m_exp = (m_left == 1) && (wd_timeout != 0) && !m_chg;
            if (m_exp && m_pulse == 0 && !pin_mode) m_pulse = PUL;
            else if (m_pulse > 0) m_pulse = m_pulse - 1;
            if (wd_timeout == 0) m_left = 0;
            else if (m_chg) m_left = wd_timeout * SEC;
            else if (m_left > 0) m_left = m_left - 1;
            if (wd_timeout == 0) m_alarm = 0;
            else if (m_exp) m_alarm = 1;
            if (sw_fs_wr) begin
                m_prev = m_cur; m_cur = sw_fs; m_fs = sw_fs;
            end else if (m_exp) begin
                m_fs = revert_sel ? m_prev : strap_fs;
                m_cur = m_fs;
            end
        end
    end

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d @%0t", req, what, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(fs_out == m_fs[4:0], tag, "fs_out vs model", fs_out, m_fs);
            chk(wd_alarm == m_alarm[0], tag, "wd_alarm vs model", wd_alarm, m_alarm);
            chk(srst_pull_low == ((m_pulse != 0) && !pin_mode), tag, "srst_pull_low vs model",
                srst_pull_low, ((m_pulse != 0) && !pin_mode));
        end
    end

    task automatic step(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write_fs(logic [4:0] v);
        sw_fs = v; sw_fs_wr = 1'b1;
        @(negedge clk);
        sw_fs_wr = 1'b0;
    endtask

    task automatic div_strobe();
        div_chg = 1'b1;
        @(negedge clk);
        div_chg = 1'b0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 190000 && !done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run did not complete actual=%0d expected=%0d", cyc_cnt, 190000);
            finish_run();
        end
    end

    initial begin
        rst = 1'b1; wd_timeout = 4'd0; revert_sel = 1'b0; pin_mode = 1'b1;
        strap_fs = 5'h0A; sw_fs = 5'h00; sw_fs_wr = 1'b0; div_chg = 1'b0;
        step(4);
        rst = 1'b0;
        step(1);
        // R1 reset state
        chk(fs_out == 5'h0A, "R1", "fs_out after reset", fs_out, 5'h0A);
        chk(wd_alarm == 1'b0, "R1", "wd_alarm after reset", wd_alarm, 0);
        chk(srst_pull_low == 1'b0, "R1", "srst_pull_low after reset", srst_pull_low, 0);

        // R2 write with watchdog off; R3 no countdown
        tag = "R2";
        write_fs(5'h11);
        chk(fs_out == 5'h11, "R2", "fs_out after write", fs_out, 5'h11);
        tag = "R3";
        step(SEC + 200);
        chk(wd_alarm == 1'b0, "R3", "no alarm with timeout off", wd_alarm, 0);

        // R3 exact expiry, R7 strap revert, R9 pulse width
        tag = "R7"; pin_mode = 1'b0; revert_sel = 1'b0; wd_timeout = 4'd1;
        write_fs(5'h13);
        step(SEC - 1);
        chk(wd_alarm == 1'b0, "R3", "alarm one edge before expiry", wd_alarm, 0);
        chk(fs_out == 5'h13, "R3", "fs_out before expiry", fs_out, 5'h13);
        step(1);
        chk(wd_alarm == 1'b1, "R6", "alarm at expiry", wd_alarm, 1);
        chk(fs_out == 5'h0A, "R7", "fs_out reverted to strap", fs_out, 5'h0A);
        chk(srst_pull_low == 1'b1, "R9", "pulse starts", srst_pull_low, 1);
        tag = "R9";
        step(PUL - 1);
        chk(srst_pull_low == 1'b1, "R9", "pulse last cycle", srst_pull_low, 1);
        chk(wd_alarm == 1'b1, "R6", "alarm held", wd_alarm, 1);
        step(1);
        chk(srst_pull_low == 1'b0, "R9", "pulse ended", srst_pull_low, 0);
        tag = "R5"; wd_timeout = 4'd0;
        step(1);
        chk(wd_alarm == 1'b0, "R5", "alarm cleared by zero timeout", wd_alarm, 0);

        // R8 software revert, R10 pin used as input
        tag = "R8"; pin_mode = 1'b1; revert_sel = 1'b1;
        write_fs(5'h07);
        wd_timeout = 4'd2;
        write_fs(5'h1C);
        step(2 * SEC - 1);
        chk(fs_out == 5'h1C, "R8", "fs_out before expiry", fs_out, 5'h1C);
        step(1);
        chk(fs_out == 5'h07, "R8", "fs_out reverted to prior write", fs_out, 5'h07);
        chk(srst_pull_low == 1'b0, "R10", "no pull in input mode", srst_pull_low, 0);
        tag = "R10"; pin_mode = 1'b0;
        step(3);
        chk(srst_pull_low == 1'b0, "R10", "no late pulse after mode flip", srst_pull_low, 0);
        wd_timeout = 4'd0;
        step(2);

        // R4 restart on a second strobe
        tag = "R4"; wd_timeout = 4'd1;
        div_strobe();
        step(600);
        div_strobe();
        step(SEC - 1);
        chk(wd_alarm == 1'b0, "R4", "no expiry from first strobe", wd_alarm, 0);
        step(1);
        chk(wd_alarm == 1'b1, "R4", "expiry one period after restart", wd_alarm, 1);
        step(PUL + 2);
        wd_timeout = 4'd0;
        step(2);

        // R5 cancel mid-count
        tag = "R5"; wd_timeout = 4'd3;
        write_fs(5'h15);
        step(1500);
        wd_timeout = 4'd0;
        step(5000);
        chk(wd_alarm == 1'b0, "R5", "cancelled count never fires", wd_alarm, 0);
        chk(fs_out == 5'h15, "R5", "fs_out kept after cancel", fs_out, 5'h15);

        // R11 expiry during an active pulse
        tag = "R11"; pin_mode = 1'b0; revert_sel = 1'b0; wd_timeout = 4'd1;
        div_strobe();
        step(SEC);
        chk(srst_pull_low == 1'b1, "R11", "first pulse on", srst_pull_low, 1);
        div_strobe();
        step(SEC);
        chk(wd_alarm == 1'b1, "R11", "second expiry alarm", wd_alarm, 1);
        step(PUL - SEC - 2);
        chk(srst_pull_low == 1'b1, "R11", "pulse still from first expiry", srst_pull_low, 1);
        step(1);
        chk(srst_pull_low == 1'b0, "R11", "pulse not extended", srst_pull_low, 0);
        wd_timeout = 4'd0;
        step(4);
        finish_run();
    end

endmodule